// File: doc/BRIEF.md
# Reference Clock Lock Monitor

This block decides when a frequency-multiplying loop has to be treated as unlocked and made to re-acquire. A free-running local clock splits time into fixed windows. In each window the block counts the rising edges of the reference input and judges the count. When several good windows follow one another, the block raises `locked` and keeps that window's count as the baseline frequency. While locked it drops lock on any of these: a missing reference, a jump in the count between two consecutive windows, or slow drift of more than 30% away from the baseline.

The mode inputs also matter. Every edge on the two primary mode pins forces a re-acquire. An edge on the auxiliary mode pin forces one only when the 3-bit configuration field holds one of four values. When lock is dropped, `relock_req` pulses so that the loop restarts its acquisition.

The controller is a three-state machine:
- **ST_ACQ** counts good windows. It moves to ST_LOCK on the SETTLE_WIN-th consecutive good window ("settle done") and moves to ST_RELOCK on a mode event ("mode kick").
- **ST_LOCK** moves to ST_RELOCK on a mode event or any reference fault ("lock lost").
- **ST_RELOCK** lasts one cycle and returns to ST_ACQ ("restart"). It stays in ST_RELOCK while mode events keep arriving ("re-kick").

Top module: `refclk_lock_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `locked` and `relock_req` are both 0. Asserting reset clears `locked` at once, without waiting for a clock edge.
- R2: A window is good when three conditions hold: its edge count is non-zero, no gap timeout occurred during it, and the count differs from the previous window's count by at most `step_thresh`. `locked` rises at the end of the SETTLE_WIN-th consecutive good window (default 3), and that window's count becomes the baseline.
- R3: Any change on `mode_pri[1]` or `mode_pri[0]` is seen after a two-flop synchronizer. After the change is driven, `locked` is still 1 after two clock edges. After the third clock edge `locked` is 0 and `relock_req` is 1.
- R4: A change on `mode_aux` forces re-acquisition only when `aux_cfg` is 3, 4, 5 or 6. For the values 0, 1, 2 and 7 it has no effect on `locked` or `relock_req`.
- R5: A missing reference forces an unlock with a `relock_req` pulse. Either of two conditions counts as missing: no rising edge for GAP_MAX local cycles (default 40), or a window with zero edges. The gap timeout acts before the window ends.
- R6: While locked, a window whose count differs from the previous count by more than `step_thresh` forces an unlock, even when the count is still inside the drift limits.
- R7: While locked, a window with count C forces an unlock when 10·C > 13·B or 10·C < 7·B, where B is the baseline.
- R8: `relock_req` is 1 for one cycle each time the block leaves lock and for each mode event. Reference faults seen while acquiring only restart the settle count and do not pulse `relock_req`.
- R9: Gradual frequency changes that stay within `step_thresh` per window and within the 30% limits keep `locked` at 1 and never pulse `relock_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous and slower than clk |
| mode_pri | input | 2 | Primary mode pins; every edge forces relock |
| mode_aux | input | 1 | Auxiliary mode pin, gated by aux_cfg |
| aux_cfg | input | 3 | Configuration field that selects whether mode_aux edges matter |
| step_thresh | input | CNT_W | Largest allowed window-to-window count change |
| locked | output | 1 | Lock indication |
| relock_req | output | 1 | Re-acquire request pulse |

## Verification
Mode-pin results are due exactly three clock edges after the pin is driven: two synchronizer flops, then the state register. The bench samples `locked` on the falling edge after the second rising edge and again after the third, and it checks that `relock_req` has returned low one cycle later. Reference-driven results arrive only at window ends, one cycle after the window closes. For those, the bench holds each reference pattern for ten 64-cycle windows, counts any `relock_req` pulses seen during that time, and compares `locked` at the end. The gap timeout is checked at GAP_MAX plus a few cycles after the reference stops, which is earlier than any window end could report it.

// File: rtl/lkm_pkg.sv
package lkm_pkg;
    typedef enum logic [1:0] {
        ST_ACQ    = 2'd0,
        ST_LOCK   = 2'd1,
        ST_RELOCK = 2'd2
    } lkm_state_e;
endpackage

// File: rtl/lkm_sync_edge.sv
// Two-flop synchronizer with one extra history flop per bit for edge detection.
module lkm_sync_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise,
    output logic [W-1:0] chg
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign chg  = s2_q ^ s3_q;
endmodule

// File: rtl/lkm_window_ctr.sv
// Counts reference edges per fixed window; flags edge gaps longer than GAP_MAX.
module lkm_window_ctr #(
    parameter int WIN_LEN = 64,
    parameter int CNT_W   = 8,
    parameter int GAP_MAX = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    output logic             win_valid,
    output logic [CNT_W-1:0] win_count,
    output logic             win_gap,
    output logic             gap_hit
);
    localparam int TW = $clog2(WIN_LEN);
    localparam int GW = $clog2(GAP_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TW-1:0]    timer_q;
    logic [CNT_W-1:0] edge_cnt_q, cnt_inc;
    logic [GW-1:0]    gap_cnt_q;
    logic             gap_seen_q, wrap;

    assign wrap    = (timer_q == TW'(WIN_LEN - 1));
    assign cnt_inc = (ref_rise && edge_cnt_q != CNT_MAX) ? edge_cnt_q + 1'b1 : edge_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q    <= '0;
            edge_cnt_q <= '0;
            win_valid  <= 1'b0;
            win_count  <= '0;
            win_gap    <= 1'b0;
            gap_seen_q <= 1'b0;
        end else begin
            timer_q   <= wrap ? '0 : timer_q + 1'b1;
            win_valid <= wrap;
            if (wrap) begin
                win_count  <= cnt_inc;
                win_gap    <= gap_seen_q | gap_hit;
                edge_cnt_q <= '0;
                gap_seen_q <= 1'b0;
            end else begin
                edge_cnt_q <= cnt_inc;
                if (gap_hit) gap_seen_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt_q <= '0;
            gap_hit   <= 1'b0;
        end else begin
            gap_hit <= !ref_rise && (gap_cnt_q == GW'(GAP_MAX - 1));
            if (ref_rise)                        gap_cnt_q <= '0;
            else if (gap_cnt_q != GW'(GAP_MAX)) gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

    // R5: the gap timeout pulses once per gap, never on two cycles in a row
    a_r5_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |=> !gap_hit);
    // R2: a window verdict is a single-cycle event
    a_r2_window_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);
endmodule

// File: rtl/refclk_lock_monitor.sv
module refclk_lock_monitor
    import lkm_pkg::*;
#(
    parameter int WIN_LEN    = 64,
    parameter int CNT_W      = 8,
    parameter int GAP_MAX    = 40,
    parameter int SETTLE_WIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [1:0]       mode_pri,
    input  logic             mode_aux,
    input  logic [2:0]       aux_cfg,
    input  logic [CNT_W-1:0] step_thresh,
    output logic             locked,
    output logic             relock_req
);
    localparam int SW = $clog2(SETTLE_WIN + 1);
    localparam int XW = CNT_W + 4;

    lkm_state_e state_q, state_d;

    logic [3:0]       rise_v, chg_v;
    logic             win_valid, win_gap, gap_hit;
    logic [CNT_W-1:0] win_count, prev_q, base_q, diff;
    logic [SW-1:0]    settle_q;
    logic [XW-1:0]    cnt_x10, base_x13, base_x7;
    logic             aux_gate, mode_evt, step_bad, win_good, drift_bad, ref_evt;

    lkm_sync_edge #(.W(4)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({mode_aux, mode_pri, ref_in}),
        .rise (rise_v),
        .chg  (chg_v)
    );

    lkm_window_ctr #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .GAP_MAX(GAP_MAX)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (rise_v[0]),
        .win_valid(win_valid),
        .win_count(win_count),
        .win_gap  (win_gap),
        .gap_hit  (gap_hit)
    );

    // The auxiliary mode pin matters only for four configuration codes
    always_comb begin
        unique case (aux_cfg)
            3'd3, 3'd4, 3'd5, 3'd6: aux_gate = 1'b1;
            default:                aux_gate = 1'b0;
        endcase
    end

    assign mode_evt = chg_v[1] | chg_v[2] | (chg_v[3] & aux_gate);

    assign diff     = (win_count > prev_q) ? win_count - prev_q : prev_q - win_count;
    assign step_bad = diff > step_thresh;
    assign win_good = (win_count != '0) && !win_gap && !step_bad;

    assign cnt_x10   = ({4'd0, win_count} << 3) + ({4'd0, win_count} << 1);
    assign base_x13  = ({4'd0, base_q} << 3) + ({4'd0, base_q} << 2) + {4'd0, base_q};
    assign base_x7   = ({4'd0, base_q} << 3) - {4'd0, base_q};
    assign drift_bad = (cnt_x10 > base_x13) || (cnt_x10 < base_x7);

    assign ref_evt = gap_hit | (win_valid & (!win_good | drift_bad));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQ: begin
                if (mode_evt)
                    state_d = ST_RELOCK;                       // mode kick
                else if (win_valid && win_good && settle_q == SW'(SETTLE_WIN - 1))
                    state_d = ST_LOCK;                         // settle done
            end
            ST_LOCK:   if (mode_evt || ref_evt) state_d = ST_RELOCK; // lock lost
            ST_RELOCK: state_d = mode_evt ? ST_RELOCK : ST_ACQ;      // re-kick / restart
            default:   state_d = ST_ACQ;
        endcase
    end

    // State register and window history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ACQ;
            settle_q <= '0;
            prev_q   <= '0;
            base_q   <= '0;
        end else begin
            state_q <= state_d;
            if (win_valid) prev_q <= win_count;
            if (state_q == ST_ACQ && state_d == ST_LOCK) base_q <= win_count;
            if (state_q != ST_ACQ || state_d != ST_ACQ)
                settle_q <= '0;
            else if (win_valid)
                settle_q <= win_good ? settle_q + 1'b1 : '0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        locked     = (state_q == ST_LOCK);
        relock_req = (state_q == ST_RELOCK);
    end

    // R3: a primary mode edge while locked drops lock on the next edge
    a_r3_mode_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && (chg_v[1] || chg_v[2])) |=> (!locked && relock_req));
    // R4: an ungated auxiliary edge, with nothing else happening, keeps lock
    a_r4_aux_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && chg_v[3] && !aux_gate && !chg_v[1] && !chg_v[2] && !ref_evt)
        |=> locked);
    // R2: lock is only gained right after a window verdict
    a_r2_lock_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_valid));
    // R2: the baseline holds while lock persists
    a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(base_q));
    // R7: a drifted window while locked ends lock
    a_r7_drift_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && win_valid && drift_bad) |=> !locked);
    // R8: leaving lock always raises the request
    a_r8_fall_requests: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> relock_req);
endmodule

// File: tb/refclk_lock_monitor_bench.sv
module refclk_lock_monitor_bench;
    localparam int WIN = 64;
    localparam int GAP = 40;
    localparam int NENT = 12;
    // period 0 = reference stopped; lock code 2 = not checked
    localparam int T_PER  [NENT] = '{8, 9, 10, 12, 0, 8, 7, 6, 12, 0, 8, 7};
    localparam int T_THR  [NENT] = '{2, 2, 2,  2,  2, 2, 2, 2, 2,  2, 0, 0};
    localparam int T_LOCK [NENT] = '{1, 1, 1,  1,  0, 1, 1, 1, 1,  0, 1, 2};
    localparam int T_PULSE[NENT] = '{0, 0, 0,  1,  1, 0, 0, 1, 1,  1, 0, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] mode_pri = 2'b00;
    logic       mode_aux = 1'b0;
    logic [2:0] aux_cfg = 3'd0;
    logic [7:0] step_thresh = 8'd2;
    logic       locked, relock_req;

    int period = 8;
    int phase = 0;
    int pulse_cnt = 0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    refclk_lock_monitor u_refclk_lock_monitor (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mode_pri(mode_pri),
        .mode_aux(mode_aux), .aux_cfg(aux_cfg), .step_thresh(step_thresh),
        .locked(locked), .relock_req(relock_req)
    );

    always #5 clk = ~clk;

    // Reference generator and pulse monitor, both away from the active edge
    always @(negedge clk) begin
        if (period == 0) begin
            phase  = 0;
            ref_in = 1'b0;
        end else begin
            phase  = (phase + 1 >= period) ? 0 : phase + 1;
            ref_in = (phase < period / 2);
        end
        if (relock_req) pulse_cnt++;
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R2";
            1, 2, 5, 6: return "R9";
            3:       return "R7 low";
            4, 9:    return "R5";
            7:       return "R7 high";
            8:       return "R6/R7";
            10:      return "R2 thr0";
            default: return "R6";
        endcase
    endfunction

    task automatic relock_at8();
        step_thresh = 8'd2;
        period = 8;
        tick(10 * WIN);
        check(locked == 1'b1, "R2 relock", int'(locked), 1);
    endtask

    task automatic mode_kick(input int which, input string tag);
        int snap;
        snap = pulse_cnt;
        if (which == 0) mode_pri[0] = ~mode_pri[0];
        else            mode_pri[1] = ~mode_pri[1];
        tick(2);
        check(locked == 1'b1, {tag, " before sync"}, int'(locked), 1);
        tick(1);
        check(locked == 1'b0 && relock_req == 1'b1, {tag, " third edge"},
              int'({locked, relock_req}), 1);
        tick(1);
        check(relock_req == 1'b0, {tag, " one cycle"}, int'(relock_req), 0);
        check(pulse_cnt - snap == 1, {tag, " pulse count"}, pulse_cnt - snap, 1);
    endtask

    initial begin
        // R1: reset state
        tick(3);
        check(locked == 1'b0 && relock_req == 1'b0, "R1 in reset",
              int'({locked, relock_req}), 0);
        rst_n = 1'b1;
        tick(1);
        check(locked == 1'b0 && relock_req == 1'b0, "R1 after release",
              int'({locked, relock_req}), 0);

        // Table of reference patterns
        for (int i = 0; i < NENT; i++) begin
            int snap;
            snap = pulse_cnt;
            period = T_PER[i];
            step_thresh = 8'(T_THR[i]);
            tick(10 * WIN);
            if (T_LOCK[i] != 2)
                check(int'(locked) == T_LOCK[i], {tag_of(i), " lock"}, int'(locked), T_LOCK[i]);
            check(int'(pulse_cnt > snap) == T_PULSE[i], {tag_of(i), " pulse"},
                  int'(pulse_cnt > snap), T_PULSE[i]);
        end

        // R3: primary mode pins, exact latency
        relock_at8();
        mode_kick(0, "R3 pri0");
        relock_at8();
        mode_kick(1, "R3 pri1");

        // R4: auxiliary pin across all configuration codes
        for (int c = 0; c < 8; c++) begin
            int snap;
            bit gated;
            gated = (c >= 3 && c <= 6);
            relock_at8();
            aux_cfg = 3'(c);
            tick(2);
            snap = pulse_cnt;
            mode_aux = ~mode_aux;
            tick(6);
            check(int'(pulse_cnt > snap) == int'(gated), "R4 aux pulse",
                  int'(pulse_cnt > snap), int'(gated));
            check(int'(locked) == int'(!gated), "R4 aux lock", int'(locked), int'(!gated));
        end

        // R5: gap timeout beats the window verdict
        relock_at8();
        begin
            int snap;
            snap = pulse_cnt;
            period = 0;
            tick(GAP + 8);
            check(locked == 1'b0, "R5 gap lock", int'(locked), 0);
            check(pulse_cnt > snap, "R5/R8 gap pulse", pulse_cnt - snap, 1);
            snap = pulse_cnt;
            tick(4 * WIN);
            check(pulse_cnt == snap, "R8 no pulse while acquiring", pulse_cnt - snap, 0);
        end

        // R1: asynchronous reset while locked
        relock_at8();
        @(posedge clk);
        #2 rst_n = 1'b0;
        #1 check(locked == 1'b0, "R1 async clear", int'(locked), 0);
        tick(2);
        rst_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule